// File: doc/BRIEF.md
# Multicast Inter-Processor Interrupt Dispatcher

This block delivers inter-processor interrupts inside a multiprocessor interrupt controller. Software targets one or more CPUs by writing a CPU bitmask to the dispatch register of one of the channels. For each channel the block holds a sticky mask of the CPUs that still owe an acknowledge. A CPU's interrupt request stays high while any channel still has that CPU's bit set.

Each CPU has its own acknowledge port. The acknowledge returns the lowest pending channel for that CPU and removes only that CPU's bit from the channel. A multicast interrupt therefore reaches each targeted CPU exactly once, in whatever order the CPUs respond. Writes and acknowledges use valid/ready handshakes. Both ready outputs are tied high, so the block never applies back-pressure and a transfer completes in every cycle where valid is high. Dispatch offsets are commands only: no state can be read back from them.

Top module: `ipi_dispatch`

## Requirements
- R1: The dispatch register of channel c sits at byte offset 0x40 + 0x10*c. A write to any other offset, including unaligned offsets such as 0x44, or offsets past the last channel such as 0x80, changes nothing.
- R2: A write to a dispatch register ORs the written mask into that channel's outstanding mask. It never removes bits that are already set.
- R3: Each dispatch write produces a `chan_trig` pulse on that channel in the cycle after the write is accepted.
- R4: An acknowledge from CPU n clears bit n of the returned channel only. The bits of other CPUs and other channels are unchanged.
- R5: If an acknowledge leaves other CPUs pending on a channel, that channel pulses `chan_trig` again. `chan_active` stays high and the remaining CPUs keep their IRQ.
- R6: After reset every outstanding mask is zero: `irq` and `chan_active` are low. The first dispatch raises IRQ only on the CPUs it targets, and CPU 0 gets none unless it is targeted.
- R7: Bits of `wr_data` at position NCPU and above are ignored.
- R8: `irq[n]` is high exactly when some channel holds bit n. CPU n's acknowledge id is the lowest such channel. When no channel holds bit n, the id is all ones (3'b111 with the defaults) and the acknowledge has no effect.
- R9: If a write and an acknowledge hit the same channel in the same cycle, the acknowledging CPU's bit is cleared before the written bits are ORed in. A fresh request for that CPU is kept.
- R10: A repeated dispatch to a CPU that is already pending is delivered once. After one acknowledge, that CPU has nothing more pending from that channel.
- R11: `wr_ready` and every `ack_ready` bit are always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write valid |
| wr_ready | output | 1 | Register write ready (always 1) |
| wr_addr | input | ADDR_W | Register byte offset |
| wr_data | input | DATA_W | CPU bitmask to dispatch |
| ack_valid | input | NCPU | Per-CPU acknowledge request |
| ack_ready | output | NCPU | Per-CPU acknowledge ready (always 1) |
| ack_id | output | NCPU*ID_W | Per-CPU returned channel, CPU n at bits n*ID_W upward |
| irq | output | NCPU | Per-CPU interrupt request |
| chan_active | output | NCH | Channel has at least one CPU outstanding |
| chan_trig | output | NCH | One-cycle trigger pulse per channel |

## Verification
The bench uses four CPUs, four channels and a 32-bit write bus. The wide bus lets writes set data bits far above the CPU count, so the ignore rule is exercised. With four channels, offsets both inside and past the dispatch window can be written, and the lowest-channel-first ordering can be seen between non-adjacent channels. The multicast is acknowledged in a non-sequential CPU order, and a write is made to collide with an acknowledge on the same channel.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam logic [7:0] DISPATCH_BASE = 8'h40;
  localparam int unsigned SLOT_SHIFT = 4;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned NCPU   = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NCH-1:0]    wr_hit,
  output logic [NCPU-1:0]   wr_bits
);
  import ipi_pkg::*;

  // R7: only the low NCPU data bits are used
  assign wr_bits = wr_data[NCPU-1:0];

  generate
    if (DATA_W > NCPU) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:NCPU];
    end
  endgenerate

  // R1: one aligned slot per channel
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT =
        ADDR_W'(DISPATCH_BASE) + ADDR_W'(c << SLOT_SHIFT);
      assign wr_hit[c] = wr_valid && (wr_addr == SLOT);
    end
  endgenerate
endmodule

// File: rtl/ipi_chan.sv
module ipi_chan #(
  parameter int unsigned NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [NCPU-1:0] wr_bits,
  input  logic [NCPU-1:0] ack_clr,
  output logic [NCPU-1:0] mask,
  output logic            trig
);
  logic [NCPU-1:0] mask_nx;

  // R9: clear first, then merge the new request
  always_comb begin
    mask_nx = mask & ~ack_clr;
    if (wr_hit) mask_nx = mask_nx | wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      trig <= 1'b0;
    end else begin
      mask <= mask_nx;
      trig <= wr_hit || ((|ack_clr) && (|mask_nx));
    end
  end

  a_r2_or_merge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((mask & $past(wr_bits)) == $past(wr_bits)));

  a_r3_trig_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> trig);

  a_r4_own_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && (|ack_clr)) |=>
      (((mask & $past(ack_clr)) == '0) &&
       ((($past(mask) & ~$past(ack_clr)) & ~mask) == '0)));

  a_r5_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack_clr) && ((mask & ~ack_clr) != '0)) |=> (trig && (mask != '0)));

  a_r6_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (mask == '0));

  a_r9_collide_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ((ack_clr & wr_bits) != '0)) |=>
      ((mask & $past(ack_clr & wr_bits)) == $past(ack_clr & wr_bits)));
endmodule

// File: rtl/ipi_pick.sv
module ipi_pick #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned ID_W = 3
) (
  input  logic [NCH-1:0]  pend,
  output logic [ID_W-1:0] id
);
  // R8: lowest pending channel wins; all ones when none
  always_comb begin
    id = '1;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (pend[c]) id = ID_W'(c);
    end
  end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ID_W  = $clog2(NCH) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [NCPU-1:0]      ack_valid,
  output logic [NCPU-1:0]      ack_ready,
  output logic [NCPU*ID_W-1:0] ack_id,
  output logic [NCPU-1:0]      irq,
  output logic [NCH-1:0]       chan_active,
  output logic [NCH-1:0]       chan_trig
);
  localparam logic [ID_W-1:0] SPUR = '1;

  logic [NCH-1:0]            wr_hit;
  logic [NCPU-1:0]           wr_bits;
  logic [NCH-1:0][NCPU-1:0]  mask_all;
  logic [NCH-1:0][NCPU-1:0]  clr_all;
  logic [NCPU-1:0][NCH-1:0]  pend_all;
  logic [NCPU-1:0][ID_W-1:0] id_all;

  // R11: never back-pressure
  assign wr_ready  = 1'b1;
  assign ack_ready = '1;

  ipi_decode #(.NCH(NCH), .NCPU(NCPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_hit   (wr_hit),
    .wr_bits  (wr_bits)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      for (genvar n = 0; n < NCPU; n++) begin : g_clr
        assign clr_all[c][n] = ack_valid[n] && (id_all[n] == ID_W'(c));
      end

      ipi_chan #(.NCPU(NCPU)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit[c]),
        .wr_bits (wr_bits),
        .ack_clr (clr_all[c]),
        .mask    (mask_all[c]),
        .trig    (chan_trig[c])
      );

      assign chan_active[c] = |mask_all[c];
    end

    for (genvar n = 0; n < NCPU; n++) begin : g_cpu
      for (genvar c = 0; c < NCH; c++) begin : g_pend
        assign pend_all[n][c] = mask_all[c][n];
      end

      ipi_pick #(.NCH(NCH), .ID_W(ID_W)) u_pick (
        .pend (pend_all[n]),
        .id   (id_all[n])
      );

      assign irq[n] = |pend_all[n];
      assign ack_id[n*ID_W +: ID_W] = id_all[n];

      a_r8_irq_has_id: assert property (@(posedge clk) disable iff (!rst_n)
        irq[n] |-> (ack_id[n*ID_W +: ID_W] != SPUR));
      a_r8_idle_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !irq[n] |-> (ack_id[n*ID_W +: ID_W] == SPUR));
    end
  endgenerate
endmodule

// File: tb/ipi_dispatch_tb_top.sv
`timescale 1ns/100ps
module ipi_dispatch_tb_top;
  localparam int NCPU = 4;
  localparam int NCH  = 4;
  localparam int ID_W = $clog2(NCH) + 1;
  localparam int SPUR = (1 << ID_W) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 wr_valid = 1'b0;
  logic                 wr_ready;
  logic [7:0]           wr_addr = '0;
  logic [31:0]          wr_data = '0;
  logic [NCPU-1:0]      ack_valid = '0;
  logic [NCPU-1:0]      ack_ready;
  logic [NCPU*ID_W-1:0] ack_id;
  logic [NCPU-1:0]      irq;
  logic [NCH-1:0]       chan_active;
  logic [NCH-1:0]       chan_trig;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  ipi_dispatch #(.NCPU(NCPU), .NCH(NCH), .ADDR_W(8), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ack_valid(ack_valid),
    .ack_ready(ack_ready), .ack_id(ack_id), .irq(irq),
    .chan_active(chan_active), .chan_trig(chan_trig)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each acknowledge id with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int n = 0; n < NCPU; n++) begin
        if (ack_valid[n]) begin
          int item;
          int got;
          got = int'(ack_id[n*ID_W +: ID_W]);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected ack", got, 0);
          end else begin
            item = exp_q.pop_front();
            chk(item == (n << 8 | got), "R8 ack id", n << 8 | got, item);
          end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
  endtask

  task automatic ack(input int cpu, input int exp);
    @(negedge clk);
    ack_valid[cpu] = 1'b1;
    exp_q.push_back(cpu << 8 | exp);
    @(negedge clk);
    ack_valid = '0;
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(irq == 0, "R6 irq in reset", irq, 0);
    chk(chan_active == 0, "R6 active in reset", chan_active, 0);
    rst_n = 1'b1;
    #1;
    chk(wr_ready && (ack_ready == '1), "R11 ready high", {wr_ready, ack_ready}, 5'h1f);
    ack(0, SPUR);
    chk(irq == 0, "R8 spurious ack no effect", irq, 0);

    // R6 first dispatch after reset: only CPU 2
    wr(8'h40, 32'h4);
    chk(irq == 4'b0100, "R6 first dispatch target only", irq, 4'b0100);
    chk(chan_trig == 4'b0001, "R3 trigger pulse", chan_trig, 1);
    @(negedge clk); #1;
    chk(chan_trig == 0, "R3 pulse one cycle", chan_trig, 0);
    ack(2, 0);
    chk(irq == 0, "R4 single target cleared", irq, 0);

    // multicast on channel 1, acknowledged 3,0,1
    wr(8'h50, 32'hB);
    chk(irq == 4'b1011, "R2 multicast irq", irq, 4'b1011);
    ack(3, 1);
    chk(irq == 4'b0011, "R4 only cpu3 cleared", irq, 4'b0011);
    chk(chan_trig == 4'b0010, "R5 retrigger", chan_trig, 2);
    chk(chan_active == 4'b0010, "R5 still active", chan_active, 2);
    ack(0, 1);
    chk(irq == 4'b0010, "R5 remaining cpu1", irq, 4'b0010);
    ack(1, 1);
    chk(irq == 0 && chan_active == 0, "R4 multicast done", {chan_active, irq}, 0);
    chk(chan_trig == 0, "R5 no retrigger when empty", chan_trig, 0);

    // repeated dispatch to pending CPU delivered once
    wr(8'h60, 32'h2);
    wr(8'h60, 32'h2);
    ack(1, 2);
    chk(irq == 0, "R10 single delivery", irq, 0);
    ack(1, SPUR);

    // R2 merge keeps existing bits
    wr(8'h60, 32'h1);
    wr(8'h60, 32'h8);
    chk(irq == 4'b1001, "R2 or merge", irq, 4'b1001);
    ack(0, 2);
    ack(3, 2);

    // lowest channel first
    wr(8'h70, 32'h1);
    wr(8'h50, 32'h1);
    ack(0, 1);
    ack(0, 3);
    ack(0, SPUR);
    chk(irq == 0, "R8 order drained", irq, 0);

    // R7 upper data bits ignored
    wr(8'h40, 32'hFFFF_FFF0);
    chk(irq == 0 && chan_active == 0, "R7 high bits ignored", {chan_active, irq}, 0);

    // R1 other offsets ignored
    wr(8'h44, 32'hF);
    wr(8'h80, 32'hF);
    wr(8'h30, 32'hF);
    chk(irq == 0 && chan_active == 0, "R1 off-slot writes ignored", {chan_active, irq}, 0);

    // R9 write and ack collide on channel 0
    wr(8'h40, 32'h1);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 8'h40; wr_data = 32'h1;
    ack_valid[0] = 1'b1;
    exp_q.push_back(0);
    @(negedge clk);
    wr_valid = 1'b0; ack_valid = '0;
    #1;
    chk(irq == 4'b0001, "R9 fresh request kept", irq, 1);
    ack(0, 0);
    ack(0, SPUR);
    chk(irq == 0, "R9 drained", irq, 0);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule